// File: doc/BRIEF.md
# Keypad Event Queue with Interrupt and Error Flags

This block keeps a circular store of decoded keypad events together with the interrupt-status and error flags that go with it. Each event is a 7-bit key code plus a pressed flag. One read port serves four kinds of access. A consuming read pops the queue. A peek returns the entry at a given offset from the head and leaves the queue as it is. The other two return the interrupt-status and error bytes, and reading the interrupt status may clear it. The active-low interrupt line is low whenever any interrupt-status bit is set.

The consuming read is unusual. It moves the head forward first and then returns the entry at the new head, so a queue that holds a single entry reads as empty. An overflow locks the queue: once the overflow error and the error interrupt are both set, every further event is discarded. A restart pulse empties the queue and clears the interrupt status, and leaves the error byte alone.

Top module: `keyq_status`

## Requirements
- R1: An accepted event is stored as one byte: bit 7 holds the pressed flag and bits 6..0 hold the key code.
- R2: A new entry goes to slot (head + length) mod DEPTH. Head and write slot both wrap modulo DEPTH (16 by default), and the length never exceeds DEPTH.
- R3: An event that arrives while the length equals DEPTH is discarded. It sets error bit 6 (queue overflow) and interrupt-status bit 3 (error).
- R4: While interrupt-status bit 3 and error bit 6 are both set, incoming events change nothing.
- R5: Every accepted event sets interrupt-status bit 0 (key activity).
- R6: A consuming read (rd_sel = 0) returns 0x00 and leaves the queue unchanged when the length is 0 or 1.
- R7: When the length is 2 or more, a consuming read advances the head by one, reduces the length by one, and returns the entry at the new head in the same cycle.
- R8: A peek (rd_sel = 1) at index n returns the entry at (head + n) mod DEPTH when n < length, and 0x00 otherwise. It never moves the head or changes the length.
- R9: A status read (rd_sel = 2) returns the interrupt-status byte. It clears the whole byte only when bit 4 (not initialised) is 0. An error read (rd_sel = 3) returns the error byte.
- R10: irq_n is low exactly when the interrupt-status byte is nonzero.
- R11: After reset the interrupt status is 0x10, the error byte is 0x00 and the queue is empty.
- R12: A restart pulse clears the interrupt status and empties the queue, and keeps the error byte.
- R13: An accepted event and a consuming read in the same cycle both take effect, so the length is unchanged, the head advances, and the new entry goes to the slot computed from the old head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Key event present this cycle |
| ev_code | input | 7 | Decoded key code |
| ev_pressed | input | 1 | 1 = pressed, 0 = released |
| restart | input | 1 | Empty the queue and clear the interrupt status |
| rd_en | input | 1 | Read access this cycle |
| rd_sel | input | 2 | 0 pop, 1 peek, 2 interrupt status, 3 error |
| rd_idx | input | $clog2(DEPTH)+1 | Peek offset from head |
| rd_data | output | 8 | Read result for the current access |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with the default DEPTH of 16. That depth is small enough to fill the queue completely, so the test reaches the full-queue overflow and the lock-out that follows it. Starting the fill from a non-zero head makes the write slot wrap past the end of the store. The peek index is one bit wider than a slot index, so the bench can peek at an offset equal to the depth and check that it returns zero.

// File: rtl/keyq_status.sv
module keyq_status #(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_valid,
  input  logic [6:0]                 ev_code,
  input  logic                       ev_pressed,
  input  logic                       restart,
  input  logic                       rd_en,
  input  logic [1:0]                 rd_sel,
  input  logic [$clog2(DEPTH):0]     rd_idx,
  output logic [7:0]                 rd_data,
  output logic                       irq_n
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [1:0] SEL_POP = 2'd0, SEL_PEEK = 2'd1, SEL_STAT = 2'd2, SEL_ERR = 2'd3;
  localparam logic [PTR_W:0] FULL_LEN = (PTR_W+1)'(DEPTH);

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] head;
  logic [PTR_W:0]   len;
  logic [7:0]       status, err;

  wire locked   = status[3] & err[6];
  wire full     = (len == FULL_LEN);
  wire take     = ev_valid & ~locked & ~full & ~restart;
  wire ovf      = ev_valid & ~locked & full & ~restart;
  wire pop      = rd_en & (rd_sel == SEL_POP) & (len > 1) & ~restart;
  wire stat_clr = rd_en & (rd_sel == SEL_STAT) & ~status[4];

  wire [PTR_W-1:0] wr_ptr   = head + len[PTR_W-1:0];
  wire [PTR_W-1:0] nxt_head = head + 1'b1;
  wire [PTR_W-1:0] peek_ptr = head + rd_idx[PTR_W-1:0];

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      case (rd_sel)
        SEL_POP:  if (len > 1) rd_data = store[nxt_head];
        SEL_PEEK: if (rd_idx < len) rd_data = store[peek_ptr];
        SEL_STAT: rd_data = status;
        default:  rd_data = err;
      endcase
    end
  end

  assign irq_n = (status == 8'h00);

  always_ff @(posedge clk) begin
    if (take) store[wr_ptr] <= {ev_pressed, ev_code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head   <= '0;
      len    <= '0;
      status <= 8'h10;
      err    <= 8'h00;
    end else if (restart) begin
      head   <= '0;
      len    <= '0;
      status <= 8'h00;
    end else begin
      if (pop) head <= nxt_head;
      case ({take, pop})
        2'b10:   len <= len + 1'b1;
        2'b01:   len <= len - 1'b1;
        default: len <= len;
      endcase
      status <= (stat_clr ? 8'h00 : status) | {4'b0, ovf, 2'b0, take};
      if (ovf) err[6] <= 1'b1;
    end
  end
endmodule

module keyq_status_chk #(
  parameter int PTR_W = 4,
  parameter int DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             restart,
  input logic             rd_en,
  input logic [1:0]       rd_sel,
  input logic [7:0]       status,
  input logic [7:0]       err,
  input logic [PTR_W-1:0] head,
  input logic [PTR_W:0]   len
);
  p_len_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    len <= (PTR_W+1)'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !restart && !(status[3] && err[6]) && len == (PTR_W+1)'(DEPTH))
    |=> (status[3] && err[6] && len == (PTR_W+1)'(DEPTH)));

  p_locked_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !restart && !rd_en && status[3] && err[6])
    |=> ($stable(len) && $stable(head)));

  p_key_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !restart && !(status[3] && err[6]) && len < (PTR_W+1)'(DEPTH))
    |=> status[0]);

  p_peek_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd1 && !ev_valid && !restart)
    |=> ($stable(len) && $stable(head)));

  p_noinit_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel == 2'd2 && status[4] && !restart) |=> status[4]);

  p_err_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err[6] |=> err[6]);
endmodule

bind keyq_status keyq_status_chk #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .restart(restart),
  .rd_en(rd_en), .rd_sel(rd_sel), .status(status), .err(err),
  .head(head), .len(len)
);

// File: tb/sim_keyq_status.sv
module sim_keyq_status;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, ev_pressed = 0, restart = 0, rd_en = 0;
  logic [6:0] ev_code = '0;
  logic [1:0] rd_sel = '0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic irq_n;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  keyq_status #(.DEPTH(DEPTH)) u0 (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic push(input logic [6:0] code, input logic pr);
    @(negedge clk); ev_valid = 1; ev_code = code; ev_pressed = pr;
    @(negedge clk); ev_valid = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input int idx, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_sel = sel; rd_idx = IW'(idx);
    #2 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic do_restart();
    @(negedge clk); restart = 1;
    @(negedge clk); restart = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R10 irq low after reset", {7'b0, irq_n}, 8'h00);
    rd(2, 0, d); check("R11 status after reset", d, 8'h10);
    rd(2, 0, d); check("R9 noinit status not cleared", d, 8'h10);
    rd(3, 0, d); check("R11 error after reset", d, 8'h00);
    rd(1, 0, d); check("R11 queue empty", d, 8'h00);
  endtask

  task automatic t_restart();
    logic [7:0] d;
    do_restart();
    rd(2, 0, d); check("R12 status cleared", d, 8'h00);
    check("R10 irq high when clear", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    push(7'h3c, 1);
    check("R10 irq low on key", {7'b0, irq_n}, 8'h00);
    rd(2, 0, d); check("R5 key flag", d, 8'h01);
    rd(2, 0, d); check("R9 status cleared by read", d, 8'h00);
    rd(1, 0, d); check("R1 pressed encoding", d, 8'hbc);
    rd(1, 1, d); check("R8 peek beyond length", d, 8'h00);
    rd(0, 0, d); check("R6 pop of single entry", d, 8'h00);
    rd(1, 0, d); check("R6 queue unchanged", d, 8'hbc);
    push(7'h55, 0);
    rd(1, 1, d); check("R1 released encoding", d, 8'h55);
    rd(0, 0, d); check("R7 pop returns new head", d, 8'h55);
    rd(1, 0, d); check("R7 head advanced", d, 8'h55);
    rd(1, 1, d); check("R7 length decreased", d, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    for (int i = 1; i <= 15; i++) push(7'(i), 0);
    rd(1, 15, d); check("R2 wrapped write slot", d, 8'h0f);
    rd(1, 16, d); check("R8 peek at depth", d, 8'h00);
    rd(2, 0, d);
    push(7'h22, 1);
    rd(3, 0, d); check("R3 overflow error bit", d, 8'h40);
    check("R3 irq on overflow", {7'b0, irq_n}, 8'h00);
    push(7'h23, 1);
    rd(1, 15, d); check("R4 locked queue unchanged", d, 8'h0f);
    rd(1, 0, d); check("R3 event dropped head intact", d, 8'h55);
    rd(2, 0, d); check("R4 status after lock", d, 8'h08);
    do_restart();
    rd(3, 0, d); check("R12 error kept", d, 8'h40);
    rd(1, 0, d); check("R12 queue emptied", d, 8'h00);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    push(7'h11, 0);
    push(7'h12, 0);
    @(negedge clk); rd_en = 1; rd_sel = 0; ev_valid = 1; ev_code = 7'h13; ev_pressed = 1;
    #2 d = rd_data;
    @(negedge clk); rd_en = 0; ev_valid = 0;
    check("R13 pop value", d, 8'h12);
    rd(1, 0, d); check("R13 head", d, 8'h12);
    rd(1, 1, d); check("R13 new entry", d, 8'h93);
    rd(1, 2, d); check("R13 length unchanged", d, 8'h00);
  endtask

  initial begin
    #5000000;
    bad++; total++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_restart();
    t_basic();
    t_overflow();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule